// File: doc/BRIEF.md
# NAND Command Sequencer

This block turns a handful of register writes into a complete NAND flash bus transaction. Software first loads the address words, the byte count for the data phase and the secondary control word. It then writes the primary control word with its go bit set. The engine then drives, one bus cycle per clock, the opening command byte and the address bytes. Depending on the control fields, it follows them with a block of write data, a closing command byte, or both. It then waits for the flash ready/busy line and, for reads, streams the requested bytes back out.

Two sticky completion flags report progress. One marks the end of the command and one marks the end of the data transfer. Each flag is cleared by writing a one to it, and their OR drives a single interrupt line. A chip-select bit in the primary control word picks which of two flash devices is enabled for the duration of the transaction. The ECC options in the secondary control word are only held and exported, and a write of zero to that word produces a one-cycle clear pulse for an external ECC engine.

Top module: `nand_cmd_seq`

## Requirements
- R1: A write to register index 0 (primary control) with bit 31 set while idle starts a transaction whose first bus cycle is a command cycle (fl_cle and fl_we high) carrying bits 7:0 of that word.
- R2: Bit 30 of the primary control word enables address cycles, and their count is bits 29:27 plus one (1 to 8). With bit 30 clear there are none. The address bytes are issued in this order: the low byte then the high byte of register index 5, then the four bytes of register index 6 from least significant upward, then 0x00 for any seventh and eighth bytes.
- R3: Bit 26 of the primary control word selects a read data phase and bit 25 selects a write data phase. Read takes precedence if both are set, and with neither set there is no data phase.
- R4: Bit 8 of register index 1 (secondary control) adds a closing command cycle carrying that word's bits 7:0. It comes after the write data when writing, and directly after the address cycles otherwise.
- R5: After the last command, address or write-data cycle, the engine spends a fixed guard time and then waits until fl_rb is high. Only then does it raise command-done, and only then does any read data begin.
- R6: The data phase moves exactly the byte count held in register index 4, with write bytes taken from wdat_in and read bytes presented on rdat_out with rdat_valid. A count of zero moves no bytes but still completes the phase.
- R7: Register index 3 holds command-done in bit 31 and data-done in bit 28. Data-done is set only when a data phase was selected. Writing a one to a bit clears it, a set in the same cycle wins over the clear, and irq_o is the OR of the two bits.
- R8: While a transaction runs, bit 19 of the primary control word drives fl_ce_n to 2'b01 (device 1) and a clear bit 19 drives it to 2'b10 (device 0). When idle, fl_ce_n is 2'b11.
- R9: A primary control write made while a transaction runs is ignored. The register reads back unchanged and no extra bus cycles appear.
- R10: Register index 2 (status) reports fl_rb in bit 30 and the engine's busy state in bit 0.
- R11: ecc_cfg presents secondary control bits {30, 29, 27}. A write of zero to register index 1 pulses ecc_clr high for exactly one cycle, starting on the clock after the write.
- R12: After reset, all writable registers and both flags read zero, the engine is idle, and fl_ce_n is 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write index |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 3 | Register read index |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | OR of the completion flags |
| ecc_cfg | output | 3 | Held ECC options {auto-generate, 2 KiB page, Reed-Solomon} |
| ecc_clr | output | 1 | One-cycle ECC clear pulse |
| fl_ce_n | output | 2 | Active-low chip enables |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_we | output | 1 | Write strobe for command, address and write data cycles |
| fl_re | output | 1 | Read strobe for read data cycles |
| fl_dq_out | output | 8 | Byte driven to the flash |
| fl_dq_in | input | 8 | Byte returned by the flash |
| fl_rb | input | 1 | Flash ready (high) / busy (low) |
| wdat_in | input | 8 | Next write-data byte |
| wdat_take | output | 1 | High in a cycle that consumes wdat_in |
| rdat_out | output | 8 | Read-data byte |
| rdat_valid | output | 1 | rdat_out holds a read byte |

## Verification
On every cycle, the embedded properties check several invariants. Command and address latches never overlap, chip enables are released when idle, and a start always lands in the opening command cycle. Data-phase counters stay below the programmed length, read data follows a ready line, and ignored control writes and the write-one-to-clear flags behave as stated. Only the bench scenarios show the full ordered byte stream for each mix of address count, direction and closing command. They also show the held-off completion under a stuck-busy flash, zero-length phases, the order of partial flag clears and the ECC pulse timing.

// File: rtl/nseq_pkg.sv
// Shared definitions for the NAND command sequencer: register indices,
// field positions and the sequencer state encoding.
package nseq_pkg;
    localparam int REG_AW    = 3;
    localparam int ADDR_SLOTS = 8;

    localparam logic [REG_AW-1:0] RI_CTRL1 = 3'd0;
    localparam logic [REG_AW-1:0] RI_CTRL2 = 3'd1;
    localparam logic [REG_AW-1:0] RI_STAT  = 3'd2;
    localparam logic [REG_AW-1:0] RI_FLAG  = 3'd3;
    localparam logic [REG_AW-1:0] RI_DLEN  = 3'd4;
    localparam logic [REG_AW-1:0] RI_ADRLO = 3'd5;
    localparam logic [REG_AW-1:0] RI_ADRHI = 3'd6;

    localparam int F_GO      = 31;
    localparam int F_ALEN_EN = 30;
    localparam int F_ALEN_LO = 27;
    localparam int F_RD      = 26;
    localparam int F_WR      = 25;
    localparam int F_CSEL    = 19;
    localparam int F_CMD2_EN = 8;
    localparam int F_ECC_AUTO = 30;
    localparam int F_ECC_2K  = 29;
    localparam int F_ECC_RS  = 27;
    localparam int F_FL_CMD  = 31;
    localparam int F_FL_DAT  = 28;
    localparam int F_ST_RB   = 30;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_CMD1, SQ_ADDR, SQ_CMD2, SQ_WAIT, SQ_RDAT, SQ_WDAT
    } sq_state_t;
endpackage

// File: rtl/nseq_regs.sv
// Register file of the sequencer: control words, address words, byte
// count, write-one-to-clear completion flags and status readback.
// Assumes one register write per cycle and combinational reads.
module nseq_regs
    import nseq_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_waddr,
    input  logic [31:0]       reg_wdata,
    input  logic [REG_AW-1:0] reg_raddr,
    output logic [31:0]       reg_rdata,
    input  logic              busy,
    input  logic              rb,
    input  logic              ev_cmd,
    input  logic              ev_dat,
    output logic              start,
    output logic [31:0]       ctrl1_q,
    output logic [31:0]       ctrl2_q,
    output logic [LEN_W-1:0]  dlen_q,
    output logic [31:0]       adrlo_q,
    output logic [31:0]       adrhi_q,
    output logic              irq_o,
    output logic              ecc_clr
);
    logic flag_cmd_q, flag_dat_q;
    logic wr_c1, wr_c2, wr_fl;

    assign wr_c1 = reg_wr && (reg_waddr == RI_CTRL1);
    assign wr_c2 = reg_wr && (reg_waddr == RI_CTRL2);
    assign wr_fl = reg_wr && (reg_waddr == RI_FLAG);
    assign start = wr_c1 && reg_wdata[F_GO] && !busy;

    // Holds the software-written words; primary control is frozen while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl1_q <= '0;
            ctrl2_q <= '0;
            dlen_q  <= '0;
            adrlo_q <= '0;
            adrhi_q <= '0;
            ecc_clr <= 1'b0;
        end else begin
            if (wr_c1 && !busy)                      ctrl1_q <= reg_wdata;
            if (wr_c2)                               ctrl2_q <= reg_wdata;
            if (reg_wr && reg_waddr == RI_DLEN)      dlen_q  <= reg_wdata[LEN_W-1:0];
            if (reg_wr && reg_waddr == RI_ADRLO)     adrlo_q <= reg_wdata;
            if (reg_wr && reg_waddr == RI_ADRHI)     adrhi_q <= reg_wdata;
            ecc_clr <= wr_c2 && (reg_wdata == 32'h0);
        end
    end

    // Completion flags: set by sequencer events, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_cmd_q <= 1'b0;
            flag_dat_q <= 1'b0;
        end else begin
            flag_cmd_q <= ev_cmd || (flag_cmd_q && !(wr_fl && reg_wdata[F_FL_CMD]));
            flag_dat_q <= ev_dat || (flag_dat_q && !(wr_fl && reg_wdata[F_FL_DAT]));
        end
    end

    assign irq_o = flag_cmd_q || flag_dat_q;

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_raddr)
            RI_CTRL1: reg_rdata = ctrl1_q;
            RI_CTRL2: reg_rdata = ctrl2_q;
            RI_STAT: begin
                reg_rdata[F_ST_RB] = rb;
                reg_rdata[0]       = busy;
            end
            RI_FLAG: begin
                reg_rdata[F_FL_CMD] = flag_cmd_q;
                reg_rdata[F_FL_DAT] = flag_dat_q;
            end
            RI_DLEN:  reg_rdata[LEN_W-1:0] = dlen_q;
            RI_ADRLO: reg_rdata = adrlo_q;
            RI_ADRHI: reg_rdata = adrhi_q;
            default:  reg_rdata = '0;
        endcase
    end

    AST_CTRL1_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_c1) |=> $stable(ctrl1_q)); // R9
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fl && reg_wdata[F_FL_CMD] && !ev_cmd) |=> !flag_cmd_q); // R7
    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_dat |=> flag_dat_q); // R7
endmodule

// File: rtl/nseq_fsm.sv
// Phase sequencer: opening command, address cycles, write data, closing
// command, guarded ready wait, read data. One bus cycle per clock.
// Assumes control registers stay stable while busy (enforced for ctrl1).
module nseq_fsm
    import nseq_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int GUARD_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [31:0]      ctrl1_q,
    input  logic [31:0]      ctrl2_q,
    input  logic [LEN_W-1:0] dlen_q,
    input  logic             rb,
    output sq_state_t        st,
    output logic [LEN_W-1:0] cnt,
    output logic             busy,
    output logic             ev_cmd,
    output logic             ev_dat
);
    localparam logic [LEN_W-1:0] GUARD_L = LEN_W'(GUARD_CYC);

    sq_state_t        nxt, post_addr;
    logic [LEN_W-1:0] cnt_d;
    logic             is_rd, is_wr, has_cmd2, len_zero, post_dat_evt;

    assign is_rd    = ctrl1_q[F_RD];
    assign is_wr    = ctrl1_q[F_WR] && !ctrl1_q[F_RD];
    assign has_cmd2 = ctrl2_q[F_CMD2_EN];
    assign len_zero = (dlen_q == '0);
    assign busy     = (st != SQ_IDLE);

    // Phase that follows the address cycles.
    always_comb begin
        post_addr    = has_cmd2 ? SQ_CMD2 : SQ_WAIT;
        post_dat_evt = 1'b0;
        if (is_wr && !len_zero) post_addr    = SQ_WDAT;
        if (is_wr && len_zero)  post_dat_evt = 1'b1;
    end

    // Next-state, counter and completion-event logic.
    always_comb begin
        nxt    = st;
        cnt_d  = cnt;
        ev_cmd = 1'b0;
        ev_dat = 1'b0;
        unique case (st)
            SQ_IDLE: if (start) begin
                nxt   = SQ_CMD1;
                cnt_d = '0;
            end
            SQ_CMD1: begin
                cnt_d = '0;
                if (ctrl1_q[F_ALEN_EN]) nxt = SQ_ADDR;
                else begin
                    nxt    = post_addr;
                    ev_dat = post_dat_evt;
                end
            end
            SQ_ADDR: begin
                cnt_d = cnt + 1'b1;
                if (cnt == LEN_W'(ctrl1_q[F_ALEN_LO +: 3])) begin
                    nxt    = post_addr;
                    cnt_d  = '0;
                    ev_dat = post_dat_evt;
                end
            end
            SQ_WDAT: begin
                cnt_d = cnt + 1'b1;
                if (cnt == dlen_q - 1'b1) begin
                    nxt    = has_cmd2 ? SQ_CMD2 : SQ_WAIT;
                    cnt_d  = '0;
                    ev_dat = 1'b1;
                end
            end
            SQ_CMD2: begin
                nxt   = SQ_WAIT;
                cnt_d = '0;
            end
            SQ_WAIT: begin
                if (cnt < GUARD_L) cnt_d = cnt + 1'b1;
                else if (rb) begin
                    ev_cmd = 1'b1;
                    cnt_d  = '0;
                    if (is_rd && !len_zero) nxt = SQ_RDAT;
                    else begin
                        nxt    = SQ_IDLE;
                        ev_dat = is_rd;
                    end
                end
            end
            SQ_RDAT: begin
                cnt_d = cnt + 1'b1;
                if (cnt == dlen_q - 1'b1) begin
                    nxt    = SQ_IDLE;
                    ev_dat = 1'b1;
                end
            end
            default: nxt = SQ_IDLE;
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= SQ_IDLE;
            cnt <= '0;
        end else begin
            st  <= nxt;
            cnt <= cnt_d;
        end
    end

    AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (st == SQ_CMD1)); // R1
    AST_READ_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_RDAT && $past(st) == SQ_WAIT) |-> $past(rb)); // R5
    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_RDAT || st == SQ_WDAT) |-> (cnt < dlen_q)); // R6
    AST_DATA_FLAG_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        ev_dat |-> (ctrl1_q[F_RD] || ctrl1_q[F_WR])); // R7
endmodule

// File: rtl/nseq_bus.sv
// Flash pin driver: maps the sequencer state to latch enables, strobes,
// the outgoing byte and chip enables. Address bytes are gathered from the
// two address words by slot.
module nseq_bus
    import nseq_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sq_state_t        st,
    input  logic [LEN_W-1:0] cnt,
    input  logic [31:0]      ctrl1_q,
    input  logic [31:0]      ctrl2_q,
    input  logic [31:0]      adrlo_q,
    input  logic [31:0]      adrhi_q,
    input  logic [7:0]       wdat_in,
    input  logic [7:0]       fl_dq_in,
    output logic [1:0]       fl_ce_n,
    output logic             fl_cle,
    output logic             fl_ale,
    output logic             fl_we,
    output logic             fl_re,
    output logic [7:0]       fl_dq_out,
    output logic             wdat_take,
    output logic [7:0]       rdat_out,
    output logic             rdat_valid
);
    localparam int SLOT_W = $clog2(ADDR_SLOTS);

    logic [7:0] slot_byte [ADDR_SLOTS];

    for (genvar g = 0; g < ADDR_SLOTS; g++) begin : g_slot
        if (g < 2) begin : g_lo
            assign slot_byte[g] = adrlo_q[8*g +: 8];
        end else if (g < 6) begin : g_hi
            assign slot_byte[g] = adrhi_q[8*(g-2) +: 8];
        end else begin : g_pad
            assign slot_byte[g] = 8'h00;
        end
    end

    // Pin levels per phase.
    always_comb begin
        fl_cle    = 1'b0;
        fl_ale    = 1'b0;
        fl_we     = 1'b0;
        fl_re     = 1'b0;
        fl_dq_out = 8'h00;
        unique case (st)
            SQ_CMD1: begin fl_cle = 1'b1; fl_we = 1'b1; fl_dq_out = ctrl1_q[7:0]; end
            SQ_ADDR: begin fl_ale = 1'b1; fl_we = 1'b1; fl_dq_out = slot_byte[cnt[SLOT_W-1:0]]; end
            SQ_CMD2: begin fl_cle = 1'b1; fl_we = 1'b1; fl_dq_out = ctrl2_q[7:0]; end
            SQ_WDAT: begin fl_we = 1'b1; fl_dq_out = wdat_in; end
            SQ_RDAT: fl_re = 1'b1;
            default: ;
        endcase
    end

    assign fl_ce_n    = (st == SQ_IDLE) ? 2'b11 : (ctrl1_q[F_CSEL] ? 2'b01 : 2'b10);
    assign wdat_take  = (st == SQ_WDAT);
    assign rdat_valid = (st == SQ_RDAT);
    assign rdat_out   = fl_dq_in;

    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_cle && fl_ale)); // R1
    AST_CE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_IDLE) |-> (fl_ce_n == 2'b11)); // R8
endmodule

// File: rtl/nand_cmd_seq.sv
// Top of the NAND command sequencer: register file, phase sequencer and
// pin driver. Assumes a single clock and synchronous active-low reset.
module nand_cmd_seq
    import nseq_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int GUARD_CYC = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_waddr,
    input  logic [31:0] reg_wdata,
    input  logic [2:0]  reg_raddr,
    output logic [31:0] reg_rdata,
    output logic        irq_o,
    output logic [2:0]  ecc_cfg,
    output logic        ecc_clr,
    output logic [1:0]  fl_ce_n,
    output logic        fl_cle,
    output logic        fl_ale,
    output logic        fl_we,
    output logic        fl_re,
    output logic [7:0]  fl_dq_out,
    input  logic [7:0]  fl_dq_in,
    input  logic        fl_rb,
    input  logic [7:0]  wdat_in,
    output logic        wdat_take,
    output logic [7:0]  rdat_out,
    output logic        rdat_valid
);
    sq_state_t        st;
    logic [LEN_W-1:0] cnt, dlen_q;
    logic [31:0]      ctrl1_q, ctrl2_q, adrlo_q, adrhi_q;
    logic             busy, start, ev_cmd, ev_dat;

    assign ecc_cfg = {ctrl2_q[F_ECC_AUTO], ctrl2_q[F_ECC_2K], ctrl2_q[F_ECC_RS]};

    nseq_regs #(.LEN_W(LEN_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .busy(busy), .rb(fl_rb), .ev_cmd(ev_cmd), .ev_dat(ev_dat),
        .start(start), .ctrl1_q(ctrl1_q), .ctrl2_q(ctrl2_q), .dlen_q(dlen_q),
        .adrlo_q(adrlo_q), .adrhi_q(adrhi_q), .irq_o(irq_o), .ecc_clr(ecc_clr)
    );

    nseq_fsm #(.LEN_W(LEN_W), .GUARD_CYC(GUARD_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .ctrl1_q(ctrl1_q),
        .ctrl2_q(ctrl2_q), .dlen_q(dlen_q), .rb(fl_rb), .st(st), .cnt(cnt),
        .busy(busy), .ev_cmd(ev_cmd), .ev_dat(ev_dat)
    );

    nseq_bus #(.LEN_W(LEN_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .st(st), .cnt(cnt), .ctrl1_q(ctrl1_q),
        .ctrl2_q(ctrl2_q), .adrlo_q(adrlo_q), .adrhi_q(adrhi_q),
        .wdat_in(wdat_in), .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n),
        .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_we(fl_we), .fl_re(fl_re),
        .fl_dq_out(fl_dq_out), .wdat_take(wdat_take), .rdat_out(rdat_out),
        .rdat_valid(rdat_valid)
    );
endmodule

// File: tb/nand_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module nand_cmd_seq_tb_top;
    typedef struct packed {
        logic [7:0] op1;
        logic [3:0] naddr;
        logic [1:0] dir;   // 0 none, 1 read, 2 write
        logic       en2;
        logic [7:0] op2;
        logic [7:0] len;
        logic       cs;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{8'h00, 4'd5, 2'd1, 1'b1, 8'h30, 8'd6, 1'b0},
        '{8'h90, 4'd1, 2'd1, 1'b0, 8'h00, 8'd4, 1'b1},
        '{8'h80, 4'd5, 2'd2, 1'b1, 8'h10, 8'd5, 1'b0},
        '{8'h60, 4'd3, 2'd0, 1'b1, 8'hD0, 8'd0, 1'b1},
        '{8'hFF, 4'd0, 2'd0, 1'b0, 8'h00, 8'd0, 1'b0},
        '{8'h05, 4'd8, 2'd1, 1'b1, 8'hE0, 8'd0, 1'b1},
        '{8'h85, 4'd2, 2'd2, 1'b0, 8'h00, 8'd0, 1'b0}
    };
    localparam logic [31:0] ADLO = 32'h0000_B2A1;
    localparam logic [31:0] ADHI = 32'hF4E3_D2C1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [2:0] reg_waddr = '0, reg_raddr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic irq_o, ecc_clr, fl_cle, fl_ale, fl_we, fl_re, fl_rb, wdat_take, rdat_valid;
    logic [2:0] ecc_cfg;
    logic [1:0] fl_ce_n;
    logic [7:0] fl_dq_out, fl_dq_in, wdat_in, rdat_out;

    int checks = 0, fails = 0;
    logic [7:0] rcnt = '0, wcnt = '0;
    int rbcnt = 0;
    logic hold_busy = 1'b0, mdl_clr = 1'b0, log_en = 1'b0;
    logic [1:0] exp_ce = 2'b11;
    logic [9:0] logv [64];
    logic [9:0] expv [64];
    int nlog = 0, nexp = 0, ce_err = 0;

    always #2.5 clk = ~clk;

    nand_cmd_seq dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .irq_o(irq_o), .ecc_cfg(ecc_cfg), .ecc_clr(ecc_clr), .fl_ce_n(fl_ce_n),
        .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_we(fl_we), .fl_re(fl_re),
        .fl_dq_out(fl_dq_out), .fl_dq_in(fl_dq_in), .fl_rb(fl_rb),
        .wdat_in(wdat_in), .wdat_take(wdat_take), .rdat_out(rdat_out),
        .rdat_valid(rdat_valid)
    );

    // Flash and data-source models.
    assign fl_dq_in = 8'hA0 + rcnt;
    assign wdat_in  = 8'h50 + wcnt;
    assign fl_rb    = (rbcnt == 0) && !hold_busy;
    always @(posedge clk) begin
        if (mdl_clr) begin rcnt <= '0; wcnt <= '0; end
        else begin
            if (fl_re) rcnt <= rcnt + 1'b1;
            if (wdat_take) wcnt <= wcnt + 1'b1;
        end
        if (fl_cle && fl_we) rbcnt <= 4;
        else if (rbcnt != 0) rbcnt <= rbcnt - 1;
    end

    // Bus logger, sampled mid-cycle.
    always @(negedge clk) begin
        if (log_en && nlog < 64) begin
            if (fl_we) begin
                logv[nlog] = {(fl_cle ? 2'd1 : fl_ale ? 2'd2 : 2'd3), fl_dq_out};
                nlog = nlog + 1;
            end
            if (rdat_valid) begin
                logv[nlog] = {2'd0, rdat_out};
                nlog = nlog + 1;
            end
            if ((fl_we || fl_re) && fl_ce_n != exp_ce) ce_err = ce_err + 1;
        end
    end

    initial begin : watchdog
        #400us;
        fails = fails + 1;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [31:0] d);
        reg_raddr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [7:0] abyte(input int k);
        if (k < 2) return ADLO[8*k +: 8];
        if (k < 6) return ADHI[8*(k-2) +: 8];
        return 8'h00;
    endfunction

    function automatic logic [31:0] mk_ctrl1(input vec_t v);
        logic [31:0] c = 32'h8000_0000 | {24'h0, v.op1};
        if (v.naddr != 0) c = c | (32'h1 << 30) | ({29'h0, 3'(v.naddr - 1)} << 27);
        if (v.dir == 2'd1) c[26] = 1'b1;
        if (v.dir == 2'd2) c[25] = 1'b1;
        c[19] = v.cs;
        return c;
    endfunction

    task automatic build_exp(input vec_t v);
        nexp = 0;
        expv[nexp++] = {2'd1, v.op1};
        for (int k = 0; k < int'(v.naddr); k++) expv[nexp++] = {2'd2, abyte(k)};
        if (v.dir == 2'd2) for (int k = 0; k < int'(v.len); k++) expv[nexp++] = {2'd3, 8'(8'h50 + k)};
        if (v.en2) expv[nexp++] = {2'd1, v.op2};
        if (v.dir == 2'd1) for (int k = 0; k < int'(v.len); k++) expv[nexp++] = {2'd0, 8'(8'hA0 + k)};
    endtask

    task automatic launch(input vec_t v);
        wreg(3'd5, ADLO);
        wreg(3'd6, ADHI);
        wreg(3'd4, {24'h0, v.len});
        wreg(3'd1, {23'h0, v.en2, v.op2});
        @(negedge clk);
        mdl_clr = 1'b1;
        @(negedge clk);
        mdl_clr = 1'b0;
        nlog = 0; ce_err = 0; log_en = 1'b1;
        exp_ce = v.cs ? 2'b01 : 2'b10;
        wreg(3'd0, mk_ctrl1(v));
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        rreg(3'd2, s);
        for (int i = 0; i < 3000 && s[0]; i++) begin
            @(negedge clk);
            rreg(3'd2, s);
        end
        log_en = 1'b0;
    endtask

    task automatic check_log(input vec_t v, input string tag);
        bit ok;
        build_exp(v);
        chk(nlog == nexp, {tag, " R2/R3/R6 cycle count"}, nlog, nexp);
        ok = (nlog == nexp);
        for (int i = 0; i < nexp && ok; i++)
            if (logv[i] !== expv[i]) begin
                ok = 0;
                chk(0, {tag, " R1/R2/R4 byte order"}, logv[i], expv[i]);
            end
        chk(ce_err == 0, {tag, " R8 chip enable"}, ce_err, 0);
    endtask

    logic [31:0] rd;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        rreg(3'd0, rd); chk(rd == 0, "R12 ctrl1 reset", rd, 0);
        rreg(3'd3, rd); chk(rd == 0, "R12 flags reset", rd, 0);
        rreg(3'd4, rd); chk(rd == 0, "R12 length reset", rd, 0);
        chk(fl_ce_n == 2'b11 && !irq_o, "R12 idle pins", {fl_ce_n, irq_o}, 3'b110);
        rreg(3'd2, rd); chk(rd == 32'h4000_0000, "R10 status idle ready", rd, 32'h4000_0000);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            launch(VEC[i]);
            wait_idle();
            check_log(VEC[i], $sformatf("vec%0d", i));
            rreg(3'd3, rd);
            chk(rd == {1'b1, 2'b00, VEC[i].dir != 0, 28'h0}, "R7 completion flags", rd,
                {1'b1, 2'b00, VEC[i].dir != 0, 28'h0});
            chk(irq_o == 1'b1, "R7 irq line set", irq_o, 1);
            wreg(3'd3, 32'h9000_0000);
            rreg(3'd3, rd);
            chk(rd == 0 && !irq_o, "R7 write-one clear", rd, 0);
        end

        // R5/R9/R10: stuck-busy flash holds completion; second start ignored
        hold_busy = 1'b1;
        @(negedge clk);
        rreg(3'd2, rd); chk(rd[30] == 1'b0, "R10 status shows busy line", rd, 0);
        launch(VEC[3]);
        repeat (40) @(negedge clk);
        rreg(3'd2, rd); chk(rd[0] == 1'b1, "R5 engine held busy", rd[0], 1);
        rreg(3'd3, rd); chk(rd[31] == 1'b0, "R5 no done while flash busy", rd, 0);
        wreg(3'd0, 32'h8000_00FF);
        rreg(3'd0, rd); chk(rd == mk_ctrl1(VEC[3]), "R9 ctrl1 unchanged", rd, mk_ctrl1(VEC[3]));
        hold_busy = 1'b0;
        wait_idle();
        check_log(VEC[3], "busyhold R9");
        rreg(3'd3, rd); chk(rd == 32'h8000_0000, "R5 done after ready", rd, 32'h8000_0000);
        wreg(3'd3, 32'h9000_0000);

        // R7 partial clear
        launch(VEC[1]);
        wait_idle();
        wreg(3'd3, 32'h8000_0000);
        rreg(3'd3, rd); chk(rd == 32'h1000_0000, "R7 partial clear", rd, 32'h1000_0000);
        chk(irq_o == 1'b1, "R7 irq held by remaining flag", irq_o, 1);
        wreg(3'd3, 32'h1000_0000);
        rreg(3'd3, rd); chk(rd == 0, "R7 second clear", rd, 0);

        // R11 ECC config and clear pulse
        wreg(3'd1, 32'h6800_0000);
        chk(ecc_cfg == 3'b111 && !ecc_clr, "R11 ecc config", {ecc_cfg, ecc_clr}, 4'b1110);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = 3'd1; reg_wdata = 32'h0;
        @(negedge clk);
        reg_wr = 1'b0;
        chk(ecc_clr == 1'b1, "R11 clear pulse high", ecc_clr, 1);
        @(negedge clk);
        chk(ecc_clr == 1'b0 && ecc_cfg == 3'b000, "R11 clear pulse one cycle", {ecc_cfg, ecc_clr}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule